// File: doc/BRIEF.md
# Direct-Mapped Copy-Back Cache Controller

This block is a direct-mapped data cache placed between a processor request port and a main-memory port. It holds 16 KB as 256 lines of eight 64-bit words. Each line has a directory entry with a stored tag, a valid flag, a dirty flag and a reference flag. Stores are handled copy-back with write-allocate. A store that hits changes only the cache line and marks it dirty. A store that misses first brings the line in and then merges the store bytes into it.

On a miss the controller checks the line it is about to replace. A clean line is overwritten. A dirty line is first sent to memory as eight word beats. The new line is then read starting at the word that missed, and the read wraps around to the start of the line. The processor gets its word, or its merged store word, in the same cycle as the first refill beat completes. No new request is accepted until the whole line is present.

The processor side uses a request/ready handshake with a byte-enable mask and a one-cycle completion strobe. The memory side moves one 64-bit word per beat. A beat is a request that is held until the memory acknowledges it.

Top module: `cb_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1, `mem_req` is 0 and `cpu_done` is 0, and every line is invalid, so the first access to any address is a miss that reads 8 beats.
- R2: Address bits [23:14] are the tag, [13:6] the line index, [5:3] the word in the line and [2:0] the byte offset. The byte offset does not change which word is accessed. `mem_addr` always has bits [2:0] equal to zero.
- R3: A read hit is accepted on a clock edge where `cpu_req` and `cpu_ready` are both 1. It raises `cpu_done` with the stored word in the following cycle and makes no memory beat.
- R4: A store hit replaces byte i of the word, bits [8i+7:8i], only where `cpu_be[i]` is 1. It returns the merged word on `cpu_rdata` and makes no memory beat. The line becomes dirty.
- R5: A store miss fetches the line, merges the store bytes into the requested word, returns that merged word, and leaves the line dirty.
- R6: A miss that replaces an invalid or clean line makes no write beat.
- R7: A miss that replaces a dirty line first makes 8 write beats of the old line, words 0 to 7 in order, at the old tag. Every write beat comes before any read beat.
- R8: A refill reads 8 beats at the new tag. Beat k reads word (w + k) mod 8, where w is the word that missed.
- R9: On a miss, `cpu_done` and the requested word appear in the cycle in which the first refill beat is acknowledged.
- R10: From the accepting edge until the last refill beat completes, `cpu_ready` stays 0.
- R11: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` are held unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 24 | Byte address |
| cpu_be | input | 8 | Byte enables for a store |
| cpu_wdata | input | 64 | Store data |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 64 | Loaded word, or the merged word for a store |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 for a write beat |
| mem_addr | output | 24 | Word-aligned byte address of the beat |
| mem_wdata | output | 64 | Write-beat data |
| mem_ack | input | 1 | Memory completes the current beat |
| mem_rdata | input | 64 | Read-beat data, valid with `mem_ack` |

## Verification
The properties assume two things about the inputs. The memory raises `mem_ack` only while `mem_req` is 1. The processor keeps `cpu_req` and its fields unchanged until the controller accepts the request. The stimulus respects both rules: the memory model decides its acknowledge only after it sees a pending beat, and the processor driver lowers its request only after the accepting edge. Under random acknowledge stalls, the checks on beat stepping and beat holding cover both the write-back and the refill phases.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOK  = 2'd1,
        ST_WBACK = 2'd2,
        ST_FILL  = 2'd3
    } cc_state_e;

endpackage

// File: rtl/cdm_dir.sv
module cdm_dir #(
    parameter int TAG_W = 10,
    parameter int IDX_W = 8,
    localparam int LINES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic             rd_ref,
    input  logic             wen,
    input  logic [TAG_W-1:0] wtag,
    input  logic             wvalid,
    input  logic             wdirty,
    input  logic             wref
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [LINES-1:0] ref_q;

    assign rd_tag   = tag_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_ref   = ref_q[idx];

    // flag bits are reset; tags are don't-care while invalid
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            ref_q   <= '0;
        end else if (wen) begin
            valid_q[idx] <= wvalid;
            dirty_q[idx] <= wdirty;
            ref_q[idx]   <= wref;
        end
    end

    always_ff @(posedge clk) begin
        if (wen) begin
            tag_q[idx] <= wtag;
        end
    end
endmodule

// File: rtl/cdm_data.sv
module cdm_data #(
    parameter int IDX_W = 8,
    parameter int WRD_W = 3,
    parameter int OFF_W = 3,
    localparam int WORD_W = 8 << OFF_W,
    localparam int BE_W   = 1 << OFF_W,
    localparam int AW     = IDX_W + WRD_W,
    localparam int DEPTH  = 1 << AW
) (
    input  logic              clk,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata,
    input  logic              wen,
    input  logic [AW-1:0]     waddr,
    input  logic [BE_W-1:0]   wbe,
    input  logic [WORD_W-1:0] wdata
);
    logic [WORD_W-1:0] arr_q [DEPTH];
    logic [WORD_W-1:0] lane_mask;

    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign lane_mask[8*b +: 8] = {8{wbe[b]}};
    end

    assign rdata = arr_q[raddr];

    always_ff @(posedge clk) begin
        if (wen) begin
            arr_q[waddr] <= (arr_q[waddr] & ~lane_mask) | (wdata & lane_mask);
        end
    end
endmodule

// File: rtl/cdm_ctrl.sv
module cdm_ctrl
    import cache_pkg::*;
#(
    parameter int TAG_W = 10,
    parameter int IDX_W = 8,
    parameter int WRD_W = 3,
    parameter int OFF_W = 3,
    localparam int ADDR_W = TAG_W + IDX_W + WRD_W + OFF_W,
    localparam int WORD_W = 8 << OFF_W,
    localparam int BE_W   = 1 << OFF_W,
    localparam int DA_W   = IDX_W + WRD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  dir_idx,
    input  logic [TAG_W-1:0]  dir_tag,
    input  logic              dir_valid,
    input  logic              dir_dirty,
    input  logic              dir_ref,
    output logic              dir_wen,
    output logic [TAG_W-1:0]  dir_wtag,
    output logic              dir_wvalid,
    output logic              dir_wdirty,
    output logic              dir_wref,
    output logic [DA_W-1:0]   dat_raddr,
    input  logic [WORD_W-1:0] dat_rdata,
    output logic              dat_wen,
    output logic [DA_W-1:0]   dat_waddr,
    output logic [BE_W-1:0]   dat_wbe,
    output logic [WORD_W-1:0] dat_wdata
);
    localparam logic [WRD_W-1:0] LAST_BEAT = '1;

    typedef struct packed {
        cc_state_e         st;
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WRD_W-1:0]  wrd;
        logic              we;
        logic [BE_W-1:0]   be;
        logic [WORD_W-1:0] wdata;
        logic [TAG_W-1:0]  vtag;
        logic [WRD_W-1:0]  cnt;
    } ctl_t;

    ctl_t q, d;

    logic [WRD_W-1:0]  fill_w;
    logic [WORD_W-1:0] fill_word;
    logic              hit;
    logic              unused_off;

    assign unused_off = ^cpu_addr[OFF_W-1:0];

    function automatic logic [WORD_W-1:0] merge_bytes(
        input logic [WORD_W-1:0] base,
        input logic [WORD_W-1:0] upd,
        input logic [BE_W-1:0]   be
    );
        logic [WORD_W-1:0] r;
        r = base;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[8*b +: 8] = upd[8*b +: 8];
        end
        return r;
    endfunction

    always_comb begin
        d          = q;
        cpu_ready  = (q.st == ST_IDLE);
        cpu_done   = 1'b0;
        cpu_rdata  = '0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        dir_idx    = q.idx;
        dir_wen    = 1'b0;
        dir_wtag   = q.tag;
        dir_wvalid = 1'b0;
        dir_wdirty = 1'b0;
        dir_wref   = 1'b0;
        dat_raddr  = {q.idx, (q.st == ST_WBACK) ? q.cnt : q.wrd};
        dat_wen    = 1'b0;
        dat_waddr  = {q.idx, q.wrd};
        dat_wbe    = q.be;
        dat_wdata  = q.wdata;
        fill_w     = q.wrd + q.cnt;
        fill_word  = (q.cnt == '0 && q.we) ? merge_bytes(mem_rdata, q.wdata, q.be) : mem_rdata;
        hit        = dir_valid && (dir_tag == q.tag);

        unique case (q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    d.st    = ST_LOOK;
                    d.tag   = cpu_addr[ADDR_W-1 -: TAG_W];
                    d.idx   = cpu_addr[OFF_W+WRD_W +: IDX_W];
                    d.wrd   = cpu_addr[OFF_W +: WRD_W];
                    d.we    = cpu_we;
                    d.be    = cpu_be;
                    d.wdata = cpu_wdata;
                    d.cnt   = '0;
                end
            end
            ST_LOOK: begin
                if (hit) begin
                    cpu_done   = 1'b1;
                    cpu_rdata  = q.we ? merge_bytes(dat_rdata, q.wdata, q.be) : dat_rdata;
                    dat_wen    = q.we;
                    // skip the directory write when nothing in it changes
                    dir_wen    = q.we || !dir_ref;
                    dir_wvalid = 1'b1;
                    dir_wdirty = dir_dirty || q.we;
                    dir_wref   = 1'b1;
                    d.st       = ST_IDLE;
                end else begin
                    d.vtag  = dir_tag;
                    // allocate: new tag, not yet valid, reference cleared
                    dir_wen = 1'b1;
                    d.st    = (dir_valid && dir_dirty) ? ST_WBACK : ST_FILL;
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {q.vtag, q.idx, q.cnt, {OFF_W{1'b0}}};
                mem_wdata = dat_rdata;
                if (mem_ack) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_BEAT) d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {q.tag, q.idx, fill_w, {OFF_W{1'b0}}};
                if (mem_ack) begin
                    dat_wen   = 1'b1;
                    dat_waddr = {q.idx, fill_w};
                    dat_wbe   = '1;
                    dat_wdata = fill_word;
                    if (q.cnt == '0) begin
                        cpu_done  = 1'b1;
                        cpu_rdata = fill_word;
                    end
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_BEAT) begin
                        dir_wen    = 1'b1;
                        dir_wvalid = 1'b1;
                        dir_wdirty = q.we;
                        dir_wref   = 1'b1;
                        d.st       = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cb_cache.sv
module cb_cache #(
    parameter int TAG_W = 10,
    parameter int IDX_W = 8,
    parameter int WRD_W = 3,
    parameter int OFF_W = 3,
    localparam int ADDR_W = TAG_W + IDX_W + WRD_W + OFF_W,
    localparam int WORD_W = 8 << OFF_W,
    localparam int BE_W   = 1 << OFF_W,
    localparam int DA_W   = IDX_W + WRD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata
);
    logic [IDX_W-1:0]  dir_idx;
    logic [TAG_W-1:0]  dir_tag, dir_wtag;
    logic              dir_valid, dir_dirty, dir_ref;
    logic              dir_wen, dir_wvalid, dir_wdirty, dir_wref;
    logic [DA_W-1:0]   dat_raddr, dat_waddr;
    logic [WORD_W-1:0] dat_rdata, dat_wdata;
    logic              dat_wen;
    logic [BE_W-1:0]   dat_wbe;

    cdm_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WRD_W(WRD_W), .OFF_W(OFF_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_be     (cpu_be),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .cpu_done   (cpu_done),
        .cpu_rdata  (cpu_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .dir_idx    (dir_idx),
        .dir_tag    (dir_tag),
        .dir_valid  (dir_valid),
        .dir_dirty  (dir_dirty),
        .dir_ref    (dir_ref),
        .dir_wen    (dir_wen),
        .dir_wtag   (dir_wtag),
        .dir_wvalid (dir_wvalid),
        .dir_wdirty (dir_wdirty),
        .dir_wref   (dir_wref),
        .dat_raddr  (dat_raddr),
        .dat_rdata  (dat_rdata),
        .dat_wen    (dat_wen),
        .dat_waddr  (dat_waddr),
        .dat_wbe    (dat_wbe),
        .dat_wdata  (dat_wdata)
    );

    cdm_dir #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (dir_idx),
        .rd_tag   (dir_tag),
        .rd_valid (dir_valid),
        .rd_dirty (dir_dirty),
        .rd_ref   (dir_ref),
        .wen      (dir_wen),
        .wtag     (dir_wtag),
        .wvalid   (dir_wvalid),
        .wdirty   (dir_wdirty),
        .wref     (dir_wref)
    );

    cdm_data #(.IDX_W(IDX_W), .WRD_W(WRD_W), .OFF_W(OFF_W)) u_data (
        .clk   (clk),
        .raddr (dat_raddr),
        .rdata (dat_rdata),
        .wen   (dat_wen),
        .waddr (dat_waddr),
        .wbe   (dat_wbe),
        .wdata (dat_wdata)
    );
endmodule

// File: rtl/cb_cache_chk.sv
module cb_cache_chk #(
    parameter int ADDR_W = 24,
    parameter int WRD_W  = 3,
    parameter int OFF_W  = 3,
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ack
);
    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready) |=> !cpu_ready);

    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !cpu_ready);

    // R2
    mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    // R7
    wb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !(mem_req && mem_we));

    // R7
    wb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (!(mem_req && mem_we) ||
            mem_addr[OFF_W +: WRD_W] == $past(mem_addr[OFF_W +: WRD_W]) + 1'b1));

    // R8
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (!(mem_req && !mem_we) ||
            (mem_addr[OFF_W +: WRD_W] == $past(mem_addr[OFF_W +: WRD_W]) + 1'b1 &&
             mem_addr[ADDR_W-1:OFF_W+WRD_W] == $past(mem_addr[ADDR_W-1:OFF_W+WRD_W]))));

    // R11
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
            $stable(mem_addr) && $stable(mem_wdata)));
endmodule

bind cb_cache cb_cache_chk u_chk (.*);

// File: tb/test_cb_cache.sv
module test_cb_cache;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [23:0] cpu_addr;
    logic [7:0]  cpu_be;
    logic [63:0] cpu_wdata;
    logic        cpu_ready, cpu_done;
    logic [63:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack;
    logic [63:0] mem_rdata;

    always #5 clk = ~clk;

    cb_cache i_cb_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit stall_en = 0;

    logic [63:0] mem_m [int unsigned];
    logic [63:0] golden [int unsigned];
    bit          log_we [$];
    int unsigned log_wa [$];
    logic [63:0] log_dat [$];

    logic [9:0] sh_tag [256];
    bit         sh_v [256];
    bit         sh_d [256];

    int          last_lat;
    int          last_nlog;
    logic [63:0] last_rdata;

    function automatic logic [63:0] init_val(int unsigned wa);
        return {wa ^ 32'h5A5A0000, (~wa) * 32'd2654435761};
    endfunction

    function automatic logic [63:0] mem_get(int unsigned wa);
        if (mem_m.exists(wa)) return mem_m[wa];
        return init_val(wa);
    endfunction

    function automatic logic [63:0] gold_get(int unsigned wa);
        if (golden.exists(wa)) return golden[wa];
        return init_val(wa);
    endfunction

    function automatic logic [63:0] merge(logic [63:0] old, logic [63:0] nw, logic [7:0] be);
        logic [63:0] r;
        r = old;
        for (int b = 0; b < 8; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    function automatic logic [23:0] mk(logic [9:0] t, logic [7:0] i, logic [2:0] w, logic [2:0] b);
        return {t, i, w, b};
    endfunction

    task automatic check(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    // memory model: decides each beat just after the clock edge
    initial begin
        bit          hold_pend;
        logic [23:0] hold_addr;
        bit          hold_we;
        bit          ack;
        int unsigned wa;
        hold_pend = 0;
        hold_addr = '0;
        hold_we   = 0;
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(posedge clk);
            #1;
            if (hold_pend) begin
                check(mem_req && mem_addr == hold_addr && mem_we == hold_we,
                      "R11", "beat held while unacknowledged", {39'd0, mem_req, mem_addr},
                      {39'd0, 1'b1, hold_addr});
            end
            if (mem_req) begin
                ack = !stall_en || ($urandom % 3 != 0);
                wa  = int'(mem_addr >> 3);
                if (ack) begin
                    log_we.push_back(mem_we);
                    log_wa.push_back(wa);
                    log_dat.push_back(mem_wdata);
                    if (mem_we) mem_m[wa] = mem_wdata;
                    else        mem_rdata = mem_get(wa);
                end
                mem_ack   = ack;
                hold_pend = !ack;
                hold_addr = mem_addr;
                hold_we   = mem_we;
            end else begin
                mem_ack   = 1'b0;
                hold_pend = 0;
            end
        end
    end

    task automatic access(bit we, logic [23:0] a, logic [7:0] be, logic [63:0] wd);
        int unsigned wa;
        logic [7:0]  idx;
        logic [9:0]  tg, otag;
        logic [2:0]  w;
        bit          hit, wb, rdy, ackrd, got;
        logic [63:0] expd, rdat;
        int          lat, nw, nrd;
        wa   = int'(a >> 3);
        idx  = a[13:6];
        tg   = a[23:14];
        w    = a[5:3];
        otag = sh_tag[idx];
        hit  = sh_v[idx] && sh_tag[idx] == tg;
        wb   = !hit && sh_v[idx] && sh_d[idx];
        if (we) golden[wa] = merge(gold_get(wa), wd, be);
        expd = gold_get(wa);
        log_we.delete();
        log_wa.delete();
        log_dat.delete();

        @(posedge clk);
        #1;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
        forever begin
            @(negedge clk);
            if (cpu_ready) break;
        end
        @(posedge clk);
        #1;
        cpu_req = 1'b0;

        lat = 0; got = 0; rdy = 0; ackrd = 0; nrd = 0; rdat = '0;
        while (!got && lat < 300) begin
            @(negedge clk);
            lat++;
            if (cpu_done) begin
                got   = 1;
                rdat  = cpu_rdata;
                rdy   = cpu_ready;
                ackrd = mem_ack && !mem_we;
                foreach (log_we[k]) if (!log_we[k]) nrd++;
            end
        end
        while (!cpu_ready) @(negedge clk);

        last_lat   = lat;
        last_nlog  = log_we.size();
        last_rdata = rdat;

        check(got, "R10", "completion strobe seen", 64'(got), 64'd1);
        check(rdat == expd, hit ? (we ? "R4" : "R3") : (we ? "R5" : "R9"), "returned word", rdat, expd);
        if (hit) begin
            check(lat == 1, we ? "R4" : "R3", "hit latency", 64'(lat), 64'd1);
            check(log_we.size() == 0, we ? "R4" : "R3", "no beats on hit", 64'(log_we.size()), 64'd0);
        end else begin
            nw = wb ? 8 : 0;
            check(log_we.size() == nw + 8, "R10", "line complete before ready", 64'(log_we.size()), 64'(nw + 8));
            if (!wb) begin
                check(log_we.size() == 0 || !log_we[0], "R6", "no write beat for clean victim",
                      64'(log_we.size() > 0 ? log_we[0] : 1'b0), 64'd0);
            end
            for (int k = 0; k < nw; k++) begin
                if (k < log_we.size()) begin
                    check(log_we[k] && log_wa[k] == {11'd0, otag, idx, 3'(k)}, "R7", "write-back beat address",
                          64'(log_wa[k]), 64'({otag, idx, 3'(k)}));
                    check(log_dat[k] == gold_get({11'd0, otag, idx, 3'(k)}), "R7", "write-back data",
                          log_dat[k], gold_get({11'd0, otag, idx, 3'(k)}));
                end
            end
            for (int k = 0; k < 8; k++) begin
                if (nw + k < log_we.size()) begin
                    check(!log_we[nw+k] && log_wa[nw+k] == {11'd0, tg, idx, 3'(w + 3'(k))}, "R8",
                          "refill beat order", 64'(log_wa[nw+k]), 64'({tg, idx, 3'(w + 3'(k))}));
                end
            end
            check(ackrd && nrd == 1, "R9", "word returned with first refill beat", 64'(nrd), 64'd1);
            check(!rdy, "R10", "ready low while refill continues", 64'(rdy), 64'd0);
            sh_tag[idx] = tg;
            sh_v[idx]   = 1;
            sh_d[idx]   = 0;
        end
        if (we) sh_d[idx] = 1;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            sh_tag[i] = '0; sh_v[i] = 0; sh_d[i] = 0;
        end
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
        cpu_addr = '0; cpu_be = '0; cpu_wdata = '0;
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cpu_ready == 1'b1, "R1", "ready after reset", 64'(cpu_ready), 64'd1);
        check(mem_req == 1'b0, "R1", "no memory request after reset", 64'(mem_req), 64'd0);
        check(cpu_done == 1'b0, "R1", "no completion after reset", 64'(cpu_done), 64'd0);

        // cold read miss at word 5: wraps 5,6,7,0..4
        access(0, mk(10'd1, 8'd3, 3'd5, 3'd0), 8'h00, '0);
        check(last_nlog == 8, "R1", "first access misses and reads a line", 64'(last_nlog), 64'd8);

        // same word, other byte offset: hit
        access(0, mk(10'd1, 8'd3, 3'd5, 3'd6), 8'h00, '0);
        check(last_lat == 1 && last_nlog == 0, "R2", "byte offset selects same word",
              64'(last_lat), 64'd1);

        // store hit with partial byte enables, then read back
        access(1, mk(10'd1, 8'd3, 3'd5, 3'd0), 8'h0F, 64'h1122_3344_5566_7788);
        access(0, mk(10'd1, 8'd3, 3'd5, 3'd0), 8'h00, '0);
        check(last_rdata[31:0] == 32'h5566_7788, "R4", "enabled low bytes merged",
              64'(last_rdata[31:0]), 64'h5566_7788);

        // conflicting tag on the dirty line: write-back then refill from word 0
        access(0, mk(10'd2, 8'd3, 3'd0, 3'd0), 8'h00, '0);
        check(last_nlog == 16, "R7", "dirty victim adds 8 write beats", 64'(last_nlog), 64'd16);

        // back to tag 1 at word 7: clean victim, data came back from memory
        access(0, mk(10'd1, 8'd3, 3'd7, 3'd0), 8'h00, '0);
        check(last_nlog == 8, "R6", "clean victim makes only read beats", 64'(last_nlog), 64'd8);
        access(0, mk(10'd1, 8'd3, 3'd5, 3'd0), 8'h00, '0);

        // store miss on a fresh line, then read it back as a hit
        access(1, mk(10'd3, 8'd9, 3'd2, 3'd0), 8'hA5, 64'hDEAD_BEEF_CAFE_F00D);
        access(0, mk(10'd3, 8'd9, 3'd2, 3'd0), 8'h00, '0);
        // the allocated line is dirty: evicting it writes it back
        access(0, mk(10'd0, 8'd9, 3'd4, 3'd0), 8'h00, '0);
        check(last_nlog == 16, "R5", "store-miss line left dirty", 64'(last_nlog), 64'd16);

        // random traffic with memory stalls
        stall_en = 1;
        void'($urandom(32'd4242));
        for (int n = 0; n < 400; n++) begin
            logic [7:0] ri;
            case ($urandom % 3)
                0:       ri = 8'd0;
                1:       ri = 8'd7;
                default: ri = 8'd255;
            endcase
            access(bit'($urandom % 2), mk(10'($urandom % 3), ri, 3'($urandom), 3'($urandom)),
                   8'($urandom), {$urandom, $urandom});
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R10 watchdog act=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule